// File: doc/BRIEF.md
# Endpoint FIFO Space Allocator

This block hands out regions of a shared endpoint FIFO memory. The memory is divided into 512-byte units, and a 128-bit occupancy map records which units are taken. An allocation request supplies an endpoint's maximum packet size and a slot count. The block rounds the packet size up to a power of two to get the segment size, multiplies it by one more than the slot count, and converts the result to whole units. It then scans the map from unit 0 for the first run of free units that is long enough. It marks that run as used and reports the byte address, which is the FIFO base plus the run's first unit times 512.

A free request names a byte address and a byte length. It releases every unit that the range touches, in one cycle. A configurable limit confines the search to the first N units of the map. One instance serves the transmit FIFO and a second instance serves the receive FIFO, each with its own base and limit. The FIFO data path and the register interface around the block are outside its scope.

Top module: `fifo_space_alloc`

## Requirements
- R1: After reset every unit is free, and alloc_done, alloc_ok, alloc_fail, alloc_addr and alloc_size are all zero.
- R2: The segment is alloc_maxp rounded up to a power of two, and a value of 0 counts as 1. The granted byte size is (alloc_slots+1) times the segment and appears on alloc_size. The unit count is that size divided by 512, rounded up.
- R3: A grant takes the lowest-numbered run of free units of the required length. alloc_addr is cfg_base + first_unit*512.
- R4: Units covered by a grant are marked occupied, so no later grant overlaps them until they are freed.
- R5: When no run fits within the limit, alloc_fail pulses with alloc_ok low, and the occupancy map is left unchanged.
- R6: Only units with an index below cfg_limit are searched. A limit above 128 acts as 128, and a limit of 0 always fails.
- R7: alloc_done pulses for exactly one cycle. It comes k clock edges after the edge that samples alloc_start, where k is the index of the last unit granted plus one, or cfg_limit+1 on failure. alloc_addr and alloc_size hold their values until the next grant.
- R8: An alloc_start that arrives while a search is running is ignored and produces neither a second response nor an allocation.
- R9: A free request with nonzero free_size clears the units from floor((free_addr-cfg_base)/512) up to, but not including, ceil((free_addr-cfg_base+free_size)/512). The change applies at the next edge. Clearing units that are already free, and naming units beyond 128, has no effect on other units.
- R10: When a free request and a grant commit fall on the same edge, both take effect. A unit named by both stays occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 20 | Byte address of unit 0, latched when a search starts |
| cfg_limit | input | 8 | Number of units that may be searched, latched when a search starts |
| alloc_start | input | 1 | One-cycle pulse that begins an allocation |
| alloc_maxp | input | 11 | Maximum packet size in bytes |
| alloc_slots | input | 2 | Slot count; the region holds slots+1 segments |
| free_valid | input | 1 | Free request strobe |
| free_addr | input | 20 | Byte address of the region to release |
| free_size | input | 20 | Byte length of the region to release |
| alloc_done | output | 1 | One-cycle pulse ending an allocation |
| alloc_ok | output | 1 | Grant, coincident with alloc_done |
| alloc_fail | output | 1 | No space, coincident with alloc_done |
| alloc_addr | output | 20 | Byte address of the last grant |
| alloc_size | output | 14 | Byte size of the last grant |

## Verification
The functions that can meet on one edge are a grant commit, which sets units, and a free request, which clears units. The bench calculates the edge on which the search for a one-unit region will reach unit 30. It raises free_valid for a range covering units 29 and 30 so that the free lands on that exact edge. The outcome is judged through two follow-up one-unit allocations. If both operations applied and the set won on unit 30, these must land on unit 29 and then on unit 31. A lost free, or a clear that wins, shows up as a different address.

// File: rtl/fifo_alloc_pkg.sv
package fifo_alloc_pkg;
  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/fifo_alloc_sizer.sv
module fifo_alloc_sizer #(
  parameter int MAXP_W    = 11,
  parameter int SLOT_W    = 2,
  parameter int UNIT_LOG2 = 9,
  parameter int BYTES_W   = MAXP_W + 1 + SLOT_W
) (
  input  logic [MAXP_W-1:0]  maxp,
  input  logic [SLOT_W-1:0]  slots,
  output logic [BYTES_W-1:0] bytes,
  output logic [BYTES_W-1:0] units
);
  localparam int SEG_W = MAXP_W + 1;

  logic [SEG_W-1:0]   seg;
  logic [BYTES_W-1:0] slot_cnt;
  logic [BYTES_W:0]   rounded;

  // smallest power of two not below maxp
  always_comb begin
    logic found;
    seg   = '0;
    found = 1'b0;
    for (int p = 0; p <= MAXP_W; p++) begin
      if (!found && ((SEG_W'(1) << p) >= {1'b0, maxp})) begin
        seg   = SEG_W'(1) << p;
        found = 1'b1;
      end
    end
    if (!$isunknown(maxp))
      assert_seg_pow2_R2: assert ($countones(seg) == 1);
  end

  always_comb begin
    slot_cnt = BYTES_W'(slots) + BYTES_W'(1);
    bytes    = slot_cnt * BYTES_W'(seg);
    rounded  = {1'b0, bytes} + (BYTES_W+1)'((1 << UNIT_LOG2) - 1);
    units    = BYTES_W'(rounded >> UNIT_LOG2);
  end
endmodule

// File: rtl/fifo_alloc_rmask.sv
module fifo_alloc_rmask #(
  parameter int BITS = 128,
  parameter int RW   = 22
) (
  input  logic [RW-1:0]   lo,
  input  logic [RW-1:0]   cnt,
  output logic [BITS-1:0] mask
);
  logic [RW-1:0] hi;
  assign hi = lo + cnt;

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    assign mask[i] = (RW'(i) >= lo) && (RW'(i) < hi);
  end
endmodule

// File: rtl/fifo_alloc_map.sv
module fifo_alloc_map #(
  parameter int BITS = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [BITS-1:0] set_mask,
  input  logic            clr_en,
  input  logic [BITS-1:0] clr_mask,
  output logic [BITS-1:0] occ
);
  logic [BITS-1:0] set_v, clr_v;
  assign set_v = set_en ? set_mask : '0;
  assign clr_v = clr_en ? clr_mask : '0;

  // a set and a clear of the same unit on one edge: set wins
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= (occ & ~clr_v) | set_v;
  end

  assert_commit_on_free_R4: assert property (@(posedge clk) disable iff (rst)
    set_en |-> ((occ & set_mask) == '0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((occ & $past(set_mask)) == $past(set_mask)));

  assert_clear_applies_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((occ & $past(clr_mask)) == '0));
endmodule

// File: rtl/fifo_alloc_scan.sv
module fifo_alloc_scan
  import fifo_alloc_pkg::*;
#(
  parameter int BITS      = 128,
  parameter int ADDR_W    = 20,
  parameter int BYTES_W   = 14,
  parameter int UNIT_LOG2 = 9,
  parameter int IDX_W     = $clog2(BITS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BYTES_W-1:0] need_in,
  input  logic [BYTES_W-1:0] bytes_in,
  input  logic [IDX_W-1:0]   limit_in,
  input  logic [ADDR_W-1:0]  base_in,
  input  logic [BITS-1:0]    occ,
  output logic               commit_en,
  output logic [IDX_W-1:0]   commit_lo,
  output logic [BYTES_W-1:0] commit_cnt,
  output logic               done,
  output logic               ok,
  output logic               fail,
  output logic [ADDR_W-1:0]  addr,
  output logic [BYTES_W-1:0] size
);
  localparam int SEL_W = $clog2(BITS);

  scan_state_e        state;
  logic [IDX_W-1:0]   idx, lim, run_lo;
  logic [BYTES_W-1:0] run, need_q, bytes_q;
  logic [ADDR_W-1:0]  base_q;
  logic               in_range, cur_free, hit;

  assign in_range   = (state == SCAN_RUN) && (idx < lim);
  assign cur_free   = in_range && !occ[idx[SEL_W-1:0]];
  assign hit        = cur_free && ((run + BYTES_W'(1)) == need_q);
  assign commit_en  = hit;
  assign commit_lo  = (run == '0) ? idx : run_lo;
  assign commit_cnt = need_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SCAN_IDLE;
      idx     <= '0;
      lim     <= '0;
      run     <= '0;
      run_lo  <= '0;
      need_q  <= '0;
      bytes_q <= '0;
      base_q  <= '0;
      done    <= 1'b0;
      ok      <= 1'b0;
      fail    <= 1'b0;
      addr    <= '0;
      size    <= '0;
    end else begin
      done <= 1'b0;
      ok   <= 1'b0;
      fail <= 1'b0;
      unique case (state)
        SCAN_IDLE: begin
          if (start) begin
            need_q  <= need_in;
            bytes_q <= bytes_in;
            base_q  <= base_in;
            lim     <= (limit_in > IDX_W'(BITS)) ? IDX_W'(BITS) : limit_in;
            idx     <= '0;
            run     <= '0;
            state   <= SCAN_RUN;
          end
        end
        SCAN_RUN: begin
          if (!in_range) begin
            done  <= 1'b1;
            fail  <= 1'b1;
            state <= SCAN_IDLE;
          end else if (hit) begin
            done  <= 1'b1;
            ok    <= 1'b1;
            addr  <= base_q + (ADDR_W'(commit_lo) << UNIT_LOG2);
            size  <= bytes_q;
            state <= SCAN_IDLE;
          end else begin
            if (cur_free) begin
              if (run == '0) run_lo <= idx;
              run <= run + BYTES_W'(1);
            end else begin
              run <= '0;
            end
            idx <= idx + IDX_W'(1);
          end
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

  assert_single_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (state == SCAN_RUN) |-> (idx <= lim && lim <= IDX_W'(BITS)));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state == SCAN_RUN && start) |=> ($stable(need_q) && $stable(base_q)));

  assert_ok_fail_excl_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (ok != fail));
endmodule

// File: rtl/fifo_space_alloc.sv
module fifo_space_alloc #(
  parameter int MAP_BITS   = 128,
  parameter int UNIT_LOG2  = 9,
  parameter int ADDR_W     = 20,
  parameter int MAXP_W     = 11,
  parameter int SLOT_W     = 2,
  parameter int LIM_W      = $clog2(MAP_BITS + 1),
  parameter int BYTES_W    = MAXP_W + 1 + SLOT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LIM_W-1:0]   cfg_limit,
  input  logic               alloc_start,
  input  logic [MAXP_W-1:0]  alloc_maxp,
  input  logic [SLOT_W-1:0]  alloc_slots,
  input  logic               free_valid,
  input  logic [ADDR_W-1:0]  free_addr,
  input  logic [ADDR_W-1:0]  free_size,
  output logic               alloc_done,
  output logic               alloc_ok,
  output logic               alloc_fail,
  output logic [ADDR_W-1:0]  alloc_addr,
  output logic [BYTES_W-1:0] alloc_size
);
  localparam int RW         = ADDR_W + 2;
  localparam int UNIT_BYTES = 1 << UNIT_LOG2;

  logic [BYTES_W-1:0]  req_bytes, req_units;
  logic [MAP_BITS-1:0] occ, set_mask, clr_mask;
  logic                commit_en, clr_en;
  logic [LIM_W-1:0]    commit_lo;
  logic [BYTES_W-1:0]  commit_cnt;
  logic [ADDR_W-1:0]   rel;
  logic [RW-1:0]       rel_end, free_lo, free_hi, free_cnt;

  fifo_alloc_sizer #(
    .MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .UNIT_LOG2(UNIT_LOG2), .BYTES_W(BYTES_W)
  ) u_sizer (
    .maxp (alloc_maxp),
    .slots(alloc_slots),
    .bytes(req_bytes),
    .units(req_units)
  );

  fifo_alloc_scan #(
    .BITS(MAP_BITS), .ADDR_W(ADDR_W), .BYTES_W(BYTES_W),
    .UNIT_LOG2(UNIT_LOG2), .IDX_W(LIM_W)
  ) u_scan (
    .clk       (clk),
    .rst       (rst),
    .start     (alloc_start),
    .need_in   (req_units),
    .bytes_in  (req_bytes),
    .limit_in  (cfg_limit),
    .base_in   (cfg_base),
    .occ       (occ),
    .commit_en (commit_en),
    .commit_lo (commit_lo),
    .commit_cnt(commit_cnt),
    .done      (alloc_done),
    .ok        (alloc_ok),
    .fail      (alloc_fail),
    .addr      (alloc_addr),
    .size      (alloc_size)
  );

  // free range in units: start rounded down, end rounded up
  always_comb begin
    rel      = free_addr - cfg_base;
    rel_end  = RW'(rel) + RW'(free_size);
    free_lo  = RW'(rel >> UNIT_LOG2);
    free_hi  = (rel_end + RW'(UNIT_BYTES - 1)) >> UNIT_LOG2;
    free_cnt = free_hi - free_lo;
    clr_en   = free_valid && (free_addr >= cfg_base) && (free_size != '0);
  end

  fifo_alloc_rmask #(.BITS(MAP_BITS), .RW(RW)) u_set_mask (
    .lo  (RW'(commit_lo)),
    .cnt (RW'(commit_cnt)),
    .mask(set_mask)
  );

  fifo_alloc_rmask #(.BITS(MAP_BITS), .RW(RW)) u_clr_mask (
    .lo  (free_lo),
    .cnt (free_cnt),
    .mask(clr_mask)
  );

  fifo_alloc_map #(.BITS(MAP_BITS)) u_map (
    .clk     (clk),
    .rst     (rst),
    .set_en  (commit_en),
    .set_mask(set_mask),
    .clr_en  (clr_en),
    .clr_mask(clr_mask),
    .occ     (occ)
  );
endmodule

// File: tb/fifo_space_alloc_bench.sv
`timescale 1ns/1ps
module fifo_space_alloc_bench;
  localparam int BASE = 'h4000;
  localparam int UB   = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] cfg_base = 20'(BASE);
  logic [7:0]  cfg_limit = 8'd128;
  logic        alloc_start = 1'b0;
  logic [10:0] alloc_maxp = '0;
  logic [1:0]  alloc_slots = '0;
  logic        free_valid = 1'b0;
  logic [19:0] free_addr = '0;
  logic [19:0] free_size = '0;
  logic        alloc_done, alloc_ok, alloc_fail;
  logic [19:0] alloc_addr;
  logic [13:0] alloc_size;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fifo_space_alloc u_fifo_space_alloc (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .alloc_start(alloc_start), .alloc_maxp(alloc_maxp), .alloc_slots(alloc_slots),
    .free_valid(free_valid), .free_addr(free_addr), .free_size(free_size),
    .alloc_done(alloc_done), .alloc_ok(alloc_ok), .alloc_fail(alloc_fail),
    .alloc_addr(alloc_addr), .alloc_size(alloc_size)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int maxp, input int slots);
    @(negedge clk);
    alloc_maxp  = 11'(maxp);
    alloc_slots = 2'(slots);
    alloc_start = 1'b1;
    @(negedge clk);
    alloc_start = 1'b0;
  endtask

  // waits for done; returns edge count since the sampling edge
  task automatic wait_done(output int k);
    k = 0;
    while (k < 300) begin
      @(negedge clk);
      k++;
      if (alloc_done) break;
    end
  endtask

  task automatic do_alloc(input int maxp, input int slots, input bit exp_ok,
                          input int exp_unit, input int exp_size, input int exp_k,
                          input string req);
    int k;
    logic [19:0] a;
    pulse_start(maxp, slots);
    wait_done(k);
    check(k == exp_k, {req, " R7 done latency"}, k, exp_k);
    check(alloc_ok == exp_ok && alloc_fail == !exp_ok, {req, " R5 ok/fail"},
          int'(alloc_ok), int'(exp_ok));
    if (exp_ok) begin
      check(alloc_addr == 20'(BASE + exp_unit * UB), {req, " R3 address"},
            int'(alloc_addr), BASE + exp_unit * UB);
      check(alloc_size == 14'(exp_size), {req, " R2 size"}, int'(alloc_size), exp_size);
    end
    a = alloc_addr;
    @(negedge clk);
    check(!alloc_done && alloc_addr == a, "R7 single pulse, address held",
          int'(alloc_done), 0);
  endtask

  task automatic do_free(input int addr, input int size);
    @(negedge clk);
    free_addr  = 20'(addr);
    free_size  = 20'(size);
    free_valid = 1'b1;
    @(negedge clk);
    free_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(!alloc_done && !alloc_ok && !alloc_fail, "R1 flags after reset",
          int'(alloc_done | alloc_ok | alloc_fail), 0);
    check(alloc_addr == '0 && alloc_size == '0, "R1 outputs after reset",
          int'(alloc_addr), 0);
  endtask

  task automatic t_sizes();
    do_alloc(512, 0, 1, 0, 512, 1, "R1 R2 empty map");
    do_alloc(100, 1, 1, 1, 256, 2, "R2 round 100");
    do_alloc(1024, 2, 1, 2, 3072, 8, "R2 R4 six units");
    do_alloc(600, 0, 1, 8, 1024, 10, "R2 R4 two units");
  endtask

  task automatic t_first_fit();
    do_free(BASE + 1 * UB, 256);
    do_alloc(64, 0, 1, 1, 64, 2, "R3 R9 reuse hole");
    do_alloc(1024, 0, 1, 10, 1024, 12, "R3 skip short hole");
    do_free(BASE + 2 * UB, 3072);
    do_alloc(1024, 1, 1, 2, 2048, 6, "R3 R9 lowest run");
  endtask

  task automatic t_limit();
    cfg_limit = 8'd12;
    do_alloc(0, 0, 1, 6, 1, 7, "R2 R6 zero maxp");
    do_alloc(1024, 0, 0, 0, 0, 13, "R5 R6 no fit in limit");
    do_alloc(64, 0, 1, 7, 64, 8, "R5 map unchanged after fail");
    cfg_limit = 8'd0;
    do_alloc(64, 0, 0, 0, 0, 1, "R6 zero limit");
    cfg_limit = 8'd128;
  endtask

  task automatic t_busy();
    int k;
    int dones;
    pulse_start(2047, 3);
    k = 0;
    dones = 0;
    while (k < 300 && dones == 0) begin
      @(negedge clk);
      k++;
      if (k == 5) alloc_start = 1'b1;
      if (k == 6) alloc_start = 1'b0;
      if (alloc_done) dones++;
    end
    check(k == 28, "R8 R7 busy grant latency", k, 28);
    check(alloc_ok && alloc_addr == 20'(BASE + 12 * UB) && alloc_size == 14'(8192),
          "R8 first request served", int'(alloc_addr), BASE + 12 * UB);
    dones = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (alloc_done) dones++;
    end
    check(dones == 0, "R8 no second response", dones, 0);
    do_alloc(64, 0, 1, 28, 64, 29, "R8 no hidden allocation");
  endtask

  task automatic t_free_edges();
    do_free(BASE + 200 * UB, 4 * UB);
    do_free(BASE + 29 * UB, 12 * UB);
    do_alloc(64, 0, 1, 29, 64, 30, "R9 harmless frees");
    do_free(BASE + 28 * UB + 100, 10);
    do_alloc(64, 0, 1, 28, 64, 29, "R9 rounded partial free");
  endtask

  task automatic t_collide();
    int k;
    pulse_start(64, 0);
    repeat (30) @(negedge clk);
    free_addr  = 20'(BASE + 29 * UB);
    free_size  = 20'(2 * UB);
    free_valid = 1'b1;
    @(negedge clk);
    free_valid = 1'b0;
    check(alloc_done && alloc_ok && alloc_addr == 20'(BASE + 30 * UB),
          "R10 grant on collision edge", int'(alloc_addr), BASE + 30 * UB);
    @(negedge clk);
    do_alloc(64, 0, 1, 29, 64, 30, "R10 free applied");
    do_alloc(64, 0, 1, 31, 64, 32, "R10 set wins");
    k = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_first_fit();
    t_limit();
    t_busy();
    t_free_edges();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule